// File: doc/BRIEF.md
# Symmetric Function Lattice

This block evaluates symmetric Boolean functions of an N-bit input word. The input bits enter a triangular lattice of two-output cells. Each cell passes the OR of its two inputs forward as its "max" output and the AND of its two inputs onward as its "min" output. Every new input bit adds one diagonal of cells. The last diagonal yields the threshold vector: bit k-1 is high when at least k input bits are set.

An exclusive-OR level compares neighbouring thresholds to form the single-count vector, whose bit k is high when exactly k input bits are set. Each threshold reaches the XOR level twice. The second copy is made by a controlled-NOT whose target is tied to constant zero.

A caller-supplied mask with one bit per possible count picks which counts make the selected output true, so any symmetric function of the inputs can be chosen at run time. A parameter can place one register stage after the lattice. That stage also captures the mask, so all outputs of a given input word appear together.

Top module: `sym_lattice`

## Requirements
- R1: For k = 1..N_BITS, thr_out bit k-1 is 1 exactly when at least k bits of in_vec are 1.
- R2: thr_out is monotone: a set bit k always has bit k-1 set as well.
- R3: exact_out bit k (k = 0..N_BITS) is 1 exactly when in_vec holds k ones, so exactly one bit of exact_out is set at any time.
- R4: sel_out equals fn_mask bit c, where c is the number of ones in in_vec. An all-zero mask gives 0, an all-ones mask gives 1, and a mask with its odd-numbered bits set gives the parity of in_vec.
- R5: With PIPE_EN = 0 the outputs follow in_vec and fn_mask combinationally. With PIPE_EN = 1 they reflect the in_vec and fn_mask values sampled at the previous rising edge of clk.
- R6: With PIPE_EN = 1, while rst_n is low, thr_out is 0, exact_out is 1 (only bit 0 set) and sel_out is 0. With PIPE_EN = 0, rst_n has no effect on the outputs.
- R7: The outputs depend only on how many bits of in_vec are 1, so any permutation of in_vec (for example, bit reversal) leaves every output unchanged.
- R8: N_BITS outside 2..16, or PIPE_EN other than 0 or 1, stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the register stage |
| in_vec | input | N_BITS | Input word whose ones are counted |
| fn_mask | input | N_BITS+1 | Bit k enables the function to be true when exactly k ones are present |
| thr_out | output | N_BITS | Threshold vector; bit k-1 means at least k ones |
| exact_out | output | N_BITS+1 | Single-count vector; bit k means exactly k ones |
| sel_out | output | 1 | Selected symmetric function |

## Verification
On every clock edge the bound checker compares the thresholds against a count of the ones. It also checks that the thresholds are monotone, that exactly one bit of the single-count vector is set and that it sits at the right position, and that the selected output follows the mask bit for that count. These checks are aligned to the configured latency. Only the bench scenarios can show the reset values of the registered variant, that the combinational variant ignores reset, that permuted input words give identical outputs, and that the registered results line up one cycle behind their inputs over an exhaustive sweep of all 256 input words.

// File: rtl/symlat_pkg.sv
package symlat_pkg;
   localparam int N_MIN = 2;
   localparam int N_MAX = 16;

   // Offset of diagonal j (1-based, j cells wide) inside a packed triangle
   function automatic int tri_off(input int j);
      return (j * (j - 1)) / 2;
   endfunction
endpackage

// File: rtl/symlat_cell.sv
// Two-output lattice cell: max = OR, min = AND
module symlat_cell (
   input  logic a_in,
   input  logic b_in,
   output logic max_out,
   output logic min_out
);
   assign max_out = a_in | b_in;
   assign min_out = a_in & b_in;
endmodule

// File: rtl/symlat_fanout.sv
// Copy gate: controlled-NOT with the control as source and a constant-0 target
module symlat_fanout (
   input  logic src_in,
   input  logic tgt_in,
   output logic keep_out,
   output logic copy_out
);
   assign keep_out = src_in;
   assign copy_out = tgt_in ^ src_in;
endmodule

// File: rtl/symlat_lattice.sv
module symlat_lattice #(
   parameter int N_BITS = 8
) (
   input  logic [N_BITS-1:0] bits_in,
   output logic [N_BITS-1:0] at_least
);
   import symlat_pkg::*;

   localparam int TRI_W = (N_BITS * (N_BITS + 1)) / 2;
   localparam int CAR_W = TRI_W - 1;

   // lvl holds diagonal j at offset tri_off(j); car holds the min chain of diagonal j
   logic [TRI_W-1:0] lvl;
   logic [CAR_W-1:0] car;

   assign lvl[0] = bits_in[0];

   for (genvar j = 2; j <= N_BITS; j++) begin : g_diag
      localparam int LB = tri_off(j);
      localparam int PB = tri_off(j - 1);
      localparam int CB = tri_off(j) - 1;

      assign car[CB] = bits_in[j-1];

      for (genvar k = 1; k < j; k++) begin : g_cell
         symlat_cell u_cell (
            .a_in    (lvl[PB+k-1]),
            .b_in    (car[CB+k-1]),
            .max_out (lvl[LB+k-1]),
            .min_out (car[CB+k])
         );
      end

      assign lvl[LB+j-1] = car[CB+j-1];
   end

   assign at_least = lvl[TRI_W-1 -: N_BITS];
endmodule

// File: rtl/symlat_xorlvl.sv
module symlat_xorlvl #(
   parameter int N_BITS = 8
) (
   input  logic [N_BITS-1:0] thr_in,
   output logic [N_BITS:0]   exact
);
   logic [N_BITS-1:0] thr_a;
   logic [N_BITS-1:0] thr_b;

   for (genvar k = 0; k < N_BITS; k++) begin : g_copy
      symlat_fanout u_copy (
         .src_in   (thr_in[k]),
         .tgt_in   (1'b0),
         .keep_out (thr_a[k]),
         .copy_out (thr_b[k])
      );
   end

   assign exact[0] = ~thr_a[0];
   for (genvar k = 1; k < N_BITS; k++) begin : g_xor
      assign exact[k] = thr_b[k-1] ^ thr_a[k];
   end
   assign exact[N_BITS] = thr_b[N_BITS-1];
endmodule

// File: rtl/symlat_select.sv
module symlat_select #(
   parameter int N_BITS = 8
) (
   input  logic [N_BITS:0] exact,
   input  logic [N_BITS:0] mask,
   output logic            sel
);
   // Single-count terms are mutually exclusive, so OR equals XOR here
   assign sel = |(exact & mask);
endmodule

// File: rtl/sym_lattice.sv
module sym_lattice #(
   parameter int N_BITS  = 8,
   parameter int PIPE_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_BITS-1:0] in_vec,
   input  logic [N_BITS:0]   fn_mask,
   output logic [N_BITS-1:0] thr_out,
   output logic [N_BITS:0]   exact_out,
   output logic              sel_out
);
   import symlat_pkg::*;

   // R8: parameter legality
   if (N_BITS < N_MIN || N_BITS > N_MAX) begin : g_bad_width
      $error("sym_lattice: N_BITS out of range");
   end
   if (PIPE_EN != 0 && PIPE_EN != 1) begin : g_bad_pipe
      $error("sym_lattice: PIPE_EN must be 0 or 1");
   end

   logic [N_BITS-1:0] thr_raw;
   logic [N_BITS-1:0] thr_use;
   logic [N_BITS:0]   mask_use;

   symlat_lattice #(.N_BITS(N_BITS)) u_lattice (
      .bits_in  (in_vec),
      .at_least (thr_raw)
   );

   if (PIPE_EN == 1) begin : g_pipe
      logic [N_BITS-1:0] thr_q;
      logic [N_BITS:0]   mask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            thr_q  <= '0;
            mask_q <= '0;
         end else begin
            thr_q  <= thr_raw;
            mask_q <= fn_mask;
         end
      end
      assign thr_use  = thr_q;
      assign mask_use = mask_q;
   end else begin : g_comb
      assign thr_use  = thr_raw;
      assign mask_use = fn_mask;
   end

   symlat_xorlvl #(.N_BITS(N_BITS)) u_xorlvl (
      .thr_in (thr_use),
      .exact  (exact_out)
   );

   symlat_select #(.N_BITS(N_BITS)) u_select (
      .exact (exact_out),
      .mask  (mask_use),
      .sel   (sel_out)
   );

   assign thr_out = thr_use;
endmodule

// File: rtl/symlat_chk.sv
module symlat_chk #(
   parameter int N_BITS  = 8,
   parameter int PIPE_EN = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_BITS-1:0] in_vec,
   input logic [N_BITS:0]   fn_mask,
   input logic [N_BITS-1:0] thr_out,
   input logic [N_BITS:0]   exact_out,
   input logic              sel_out
);
   localparam int CW = $clog2(N_BITS + 1);

   logic [CW-1:0]     ref_now;
   logic [CW-1:0]     ref_q;
   logic [CW-1:0]     ref_use;
   logic [N_BITS:0]   mref_q;
   logic [N_BITS:0]   mref_use;
   logic [N_BITS-1:0] exp_thr;

   assign ref_now = CW'($countones(in_vec));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         mref_q <= '0;
      end else begin
         ref_q  <= ref_now;
         mref_q <= fn_mask;
      end
   end

   // R5: reference aligned to the configured latency
   assign ref_use  = (PIPE_EN != 0) ? ref_q  : ref_now;
   assign mref_use = (PIPE_EN != 0) ? mref_q : fn_mask;

   always_comb begin
      for (int k = 1; k <= N_BITS; k++) begin
         exp_thr[k-1] = (32'(ref_use) >= k);
      end
   end

   assert_thr_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      thr_out == exp_thr)
      else $error("threshold vector does not match count");

   assert_thr_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((thr_out >> 1) & ~thr_out) == '0)
      else $error("threshold vector not monotone");

   assert_exact_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(exact_out) == 1)
      else $error("single-count vector not one-hot");

   assert_exact_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exact_out[ref_use] == 1'b1)
      else $error("single-count bit at wrong index");

   assert_sel_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_out == mref_use[ref_use])
      else $error("selected output does not follow mask");
endmodule

bind sym_lattice symlat_chk #(.N_BITS(N_BITS), .PIPE_EN(PIPE_EN)) u_symlat_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_vec    (in_vec),
   .fn_mask   (fn_mask),
   .thr_out   (thr_out),
   .exact_out (exact_out),
   .sel_out   (sel_out)
);

// File: tb/sym_lattice_bench.sv
module sym_lattice_bench;
   localparam int N = 8;

   typedef struct packed {
      logic [N-1:0] thr;
      logic [N:0]   exact;
      logic         sel;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] in_r = '0;
   logic [N:0]   mask_r = '0;

   logic [N-1:0] thr_p, thr_c;
   logic [N:0]   exact_p, exact_c;
   logic         sel_p, sel_c;

   int checks = 0;
   int fails  = 0;
   exp_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz

   sym_lattice #(.N_BITS(N), .PIPE_EN(1)) u_sym_lattice (
      .clk(clk), .rst_n(rst_n), .in_vec(in_r), .fn_mask(mask_r),
      .thr_out(thr_p), .exact_out(exact_p), .sel_out(sel_p)
   );

   sym_lattice #(.N_BITS(N), .PIPE_EN(0)) u_sym_lattice_comb (
      .clk(clk), .rst_n(rst_n), .in_vec(in_r), .fn_mask(mask_r),
      .thr_out(thr_c), .exact_out(exact_c), .sel_out(sel_c)
   );

   function automatic exp_t model(input logic [N-1:0] v, input logic [N:0] m);
      exp_t e;
      int   c;
      c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      for (int k = 1; k <= N; k++) e.thr[k-1] = (c >= k);
      e.exact = '0;
      e.exact[c] = 1'b1;
      e.sel = m[c];
      return e;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
      checks++;
      if (got !== expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, expv);
      end
   endtask

   // Driver: apply at falling edge, check the combinational copy, queue for the registered copy
   task automatic drive(input logic [N-1:0] v, input logic [N:0] m);
      exp_t e;
      @(negedge clk);
      in_r   = v;
      mask_r = m;
      e = model(v, m);
      sb_q.push_back(e);
      #1;
      chk("R1 comb thr", 32'(thr_c), 32'(e.thr));
      chk("R2 comb monotone", 32'((thr_c >> 1) & ~thr_c), 32'd0);
      chk("R3 comb exact", 32'(exact_c), 32'(e.exact));
      chk("R4 comb sel", 32'(sel_c), 32'(e.sel));
   endtask

   // Monitor: registered copy shows the item one edge later
   always begin
      exp_t e;
      @(posedge clk);
      #2;
      if (rst_n && sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk("R5/R1 pipe thr", 32'(thr_p), 32'(e.thr));
         chk("R5/R3 pipe exact", 32'(exact_p), 32'(e.exact));
         chk("R5/R4 pipe sel", 32'(sel_p), 32'(e.sel));
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [N-1:0] rv;
      logic [N:0]   sv_exact;
      logic [N-1:0] sv_thr;
      logic         sv_sel;

      // R6: reset behaviour of both variants
      in_r   = '1;
      mask_r = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R6 reset thr", 32'(thr_p), 32'd0);
      chk("R6 reset exact", 32'(exact_p), 32'd1);
      chk("R6 reset sel", 32'(sel_p), 32'd0);
      chk("R6 comb ignores reset thr", 32'(thr_c), 32'hFF);
      chk("R6 comb ignores reset sel", 32'(sel_c), 32'd1);
      rst_n = 1'b1;

      // R1 R3 R4 R5: exhaustive sweep with varying masks
      for (int v = 0; v < (1 << N); v++) begin
         drive(N'(v), (N+1)'(v * 37 + 11));
      end

      // R4: fixed masks
      for (int v = 0; v < 16; v++) begin
         drive(N'(v * 13 + 5), '0);
         chk("R4 zero mask", 32'(sel_c), 32'd0);
         drive(N'(v * 13 + 5), '1);
         chk("R4 ones mask", 32'(sel_c), 32'd1);
         drive(N'(v * 13 + 5), 9'b010101010);
         chk("R4 parity mask", 32'(sel_c), 32'($countones(N'(v * 13 + 5)) % 2));
      end

      // R7: bit-reversed words give identical outputs
      for (int v = 1; v < 40; v += 3) begin
         drive(N'(v * 29), 9'b100110101);
         sv_thr = thr_c;
         sv_exact = exact_c;
         sv_sel = sel_c;
         for (int i = 0; i < N; i++) rv[i] = in_r[N-1-i];
         drive(rv, 9'b100110101);
         chk("R7 perm thr", 32'(thr_c), 32'(sv_thr));
         chk("R7 perm exact", 32'(exact_c), 32'(sv_exact));
         chk("R7 perm sel", 32'(sel_c), 32'(sv_sel));
      end

      repeat (4) @(posedge clk);
      chk("R5 scoreboard drained", 32'(sb_q.size()), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule